// File: doc/BRIEF.md
# Overhead Bit Persistence Validator

The block sits behind a line receiver that delivers one group of overhead bits on every superframe and one operations-channel message on every half-superframe. For each of the two sources it keeps a validated copy of the data and raises a one-cycle interrupt pulse. A 2-bit persistence field, one per source, decides when that happens. The block can report on every arrival or only when the data changes. It can also wait until the same new value has arrived on two or three consecutive occasions. The two sources are filtered independently, each with its own field and its own strobe.

On every superframe strobe the block also takes two per-frame error indications from the receiver: a local CRC mismatch and the received far-end block error bit. When the matching enable is set, it raises a status interrupt whose flags are active-low. On every qualifying frame it also emits a counter-increment pulse for the block error counters, whatever the enables are. A single 8-bit control register holds the enables and both persistence fields.

Top module: `ovp_validator`

## Requirements
- R1: The control register reads 0x00 after reset. A write stores bits 7..1 and bit 0 always reads 0. Layout: bit 7 is the CRC interrupt enable, bit 6 is a stored spare, bit 5 is the far-end error interrupt enable, bits 4..3 are the overhead persistence field and bits 2..1 are the message persistence field.
- R2: With persistence code 00, every strobe loads the data into the validated register and pulses the interrupt, even when the data is unchanged.
- R3: With code 01, a strobe pulses the interrupt and loads the data only when the data differs from the validated value.
- R4: With code 10 (or 11), the interrupt fires and the data is loaded when the same value, different from the validated one, arrives on 2 (or 3) consecutive strobes. A differing value restarts the run at 1. A strobe carrying the validated value clears the run.
- R5: The validated overhead register changes only in the cycle in which the overhead interrupt pulses, one clock after the strobe that caused it.
- R6: Messages follow the same four codes as R2 to R4, using the message field and counting message strobes only. Message filtering is independent of overhead strobes and the overhead field.
- R7: With the CRC interrupt enabled, a superframe with a CRC mismatch pulses the status interrupt with the near-end flag at 0. With the enable clear, it does not pulse.
- R8: With the far-end interrupt enabled, a superframe carrying a far-end error bit of 0 pulses the status interrupt with the far-end flag at 0. With the enable clear, it does not pulse.
- R9: The near-end and far-end counter-increment pulses follow every qualifying superframe, whatever the interrupt enables are.
- R10: No interrupt pulse appears without a strobe of the matching source in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_o | output | 8 | Control register contents |
| sf_valid | input | 1 | Superframe strobe |
| sf_ovh | input | OVH_W | Overhead bits of this superframe |
| sf_crc_err | input | 1 | Local CRC mismatch for this superframe |
| sf_febe | input | 1 | Received far-end block error bit (0 = error) |
| hsf_valid | input | 1 | Half-superframe message strobe |
| hsf_msg | input | EOC_W | Operations-channel message |
| ovh_data | output | OVH_W | Validated overhead bits |
| ovh_irq | output | 1 | Overhead interrupt pulse |
| eoc_data | output | EOC_W | Validated message |
| eoc_irq | output | 1 | Message interrupt pulse |
| stat_irq | output | 1 | Status interrupt pulse |
| stat_ne_ok | output | 1 | Near-end flag, 0 = CRC mismatch in last superframe |
| stat_fe_ok | output | 1 | Far-end flag, 0 = far-end error in last superframe |
| ne_cnt_inc | output | 1 | Near-end block error counter increment |
| fe_cnt_inc | output | 1 | Far-end block error counter increment |

## Verification
The assertions check on every cycle that the validated registers only move together with their interrupt pulse, and that no pulse appears without a preceding strobe. They also check that code 00 always interrupts, and that a status interrupt always carries at least one low flag with the matching counter pulse. The run counting of codes 10 and 11 can only be shown by the bench's scenarios: runs broken by a different value or by the validated value, and the separation of overhead from message strobes. The same holds for the control register layout and the effect of the enables.

// File: rtl/ovp_pkg.sv
package ovp_pkg;

    localparam int CFG_W = 8;
    localparam int RUN_W = 2;

    typedef enum logic [1:0] {
        PM_ALWAYS = 2'b00,
        PM_CHANGE = 2'b01,
        PM_TWO    = 2'b10,
        PM_THREE  = 2'b11
    } pmode_e;

    // Control fields, msb first; bit 0 of the byte is a constant zero.
    typedef struct packed {
        logic   crc_ie;
        logic   spare;
        logic   febe_ie;
        pmode_e ovh_mode;
        pmode_e eoc_mode;
    } ctrl_t;

endpackage

// File: rtl/ovp_ctrl.sv
module ovp_ctrl
    import ovp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output ctrl_t            ctrl_o,
    output logic [CFG_W-1:0] byte_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we_i) begin
            ctrl_d = ctrl_t'(wdata_i[CFG_W-1:1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;
    assign byte_o = {ctrl_q, 1'b0};

endmodule

// File: rtl/ovp_persist.sv
module ovp_persist
    import ovp_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  pmode_e       mode_i,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] val_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0]     val;
        logic [W-1:0]     cand;
        logic [RUN_W-1:0] run;
        logic             irq;
    } st_t;

    st_t st_d, st_q;
    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        need    = (mode_i == PM_THREE) ? RUN_W'(3) : RUN_W'(2);
        run_inc = st_q.run + RUN_W'(1);
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (valid_i) begin
            unique case (mode_i)
                PM_ALWAYS: begin
                    st_d.val = data_i;
                    st_d.irq = 1'b1;
                    st_d.run = '0;
                end
                PM_CHANGE: begin
                    st_d.run = '0;
                    if (data_i != st_q.val) begin
                        st_d.val = data_i;
                        st_d.irq = 1'b1;
                    end
                end
                default: begin
                    if (data_i == st_q.val) begin
                        st_d.run = '0;
                    end else if ((st_q.run != '0) && (data_i == st_q.cand)) begin
                        if (run_inc == need) begin
                            st_d.val = data_i;
                            st_d.irq = 1'b1;
                            st_d.run = '0;
                        end else begin
                            st_d.run = run_inc;
                        end
                    end else begin
                        st_d.cand = data_i;
                        st_d.run  = RUN_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o = st_q.val;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/ovp_status.sv
module ovp_status (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic crc_err_i,
    input  logic febe_i,
    input  logic crc_ie_i,
    input  logic febe_ie_i,
    output logic irq_o,
    output logic ne_ok_o,
    output logic fe_ok_o,
    output logic ne_inc_o,
    output logic fe_inc_o
);

    typedef struct packed {
        logic irq;
        logic ne_ok;
        logic fe_ok;
        logic ne_inc;
        logic fe_inc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.irq    = 1'b0;
        st_d.ne_inc = 1'b0;
        st_d.fe_inc = 1'b0;
        if (valid_i) begin
            st_d.ne_ok  = !crc_err_i;
            st_d.fe_ok  = febe_i;
            st_d.ne_inc = crc_err_i;
            st_d.fe_inc = !febe_i;
            st_d.irq    = (crc_ie_i && crc_err_i) || (febe_ie_i && !febe_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{irq: 1'b0, ne_ok: 1'b1, fe_ok: 1'b1, ne_inc: 1'b0, fe_inc: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o    = st_q.irq;
    assign ne_ok_o  = st_q.ne_ok;
    assign fe_ok_o  = st_q.fe_ok;
    assign ne_inc_o = st_q.ne_inc;
    assign fe_inc_o = st_q.fe_inc;

endmodule

// File: rtl/ovp_validator.sv
module ovp_validator
    import ovp_pkg::*;
#(
    parameter int OVH_W = 11,
    parameter int EOC_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_o,
    input  logic             sf_valid,
    input  logic [OVH_W-1:0] sf_ovh,
    input  logic             sf_crc_err,
    input  logic             sf_febe,
    input  logic             hsf_valid,
    input  logic [EOC_W-1:0] hsf_msg,
    output logic [OVH_W-1:0] ovh_data,
    output logic             ovh_irq,
    output logic [EOC_W-1:0] eoc_data,
    output logic             eoc_irq,
    output logic             stat_irq,
    output logic             stat_ne_ok,
    output logic             stat_fe_ok,
    output logic             ne_cnt_inc,
    output logic             fe_cnt_inc
);

    ctrl_t ctrl;

    ovp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .ctrl_o  (ctrl),
        .byte_o  (cfg_o)
    );

    ovp_persist #(.W(OVH_W)) u_ovh (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (ctrl.ovh_mode),
        .valid_i (sf_valid),
        .data_i  (sf_ovh),
        .val_o   (ovh_data),
        .irq_o   (ovh_irq)
    );

    ovp_persist #(.W(EOC_W)) u_eoc (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (ctrl.eoc_mode),
        .valid_i (hsf_valid),
        .data_i  (hsf_msg),
        .val_o   (eoc_data),
        .irq_o   (eoc_irq)
    );

    ovp_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (sf_valid),
        .crc_err_i (sf_crc_err),
        .febe_i    (sf_febe),
        .crc_ie_i  (ctrl.crc_ie),
        .febe_ie_i (ctrl.febe_ie),
        .irq_o     (stat_irq),
        .ne_ok_o   (stat_ne_ok),
        .fe_ok_o   (stat_fe_ok),
        .ne_inc_o  (ne_cnt_inc),
        .fe_inc_o  (fe_cnt_inc)
    );

endmodule

// File: rtl/ovp_validator_chk.sv
module ovp_validator_chk #(
    parameter int OVH_W = 11,
    parameter int EOC_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       cfg_o,
    input logic             sf_valid,
    input logic             hsf_valid,
    input logic [OVH_W-1:0] ovh_data,
    input logic             ovh_irq,
    input logic [EOC_W-1:0] eoc_data,
    input logic             eoc_irq,
    input logic             stat_irq,
    input logic             stat_ne_ok,
    input logic             stat_fe_ok,
    input logic             ne_cnt_inc,
    input logic             fe_cnt_inc
);

    AST_MODE_ZERO_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_valid && cfg_o[4:3] == 2'b00) |=> ovh_irq); // R2

    AST_OVH_LOAD_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovh_data) |-> ovh_irq); // R5

    AST_EOC_LOAD_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eoc_data) |-> eoc_irq); // R6

    AST_OVH_IRQ_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        ovh_irq |-> $past(sf_valid)); // R10

    AST_EOC_IRQ_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> $past(hsf_valid)); // R10

    AST_STAT_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stat_irq |-> (!stat_ne_ok || !stat_fe_ok)); // R7

    AST_NE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_irq && !stat_ne_ok) |-> ne_cnt_inc); // R9

    AST_FE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_irq && !stat_fe_ok) |-> fe_cnt_inc); // R9

endmodule

bind ovp_validator ovp_validator_chk #(.OVH_W(OVH_W), .EOC_W(EOC_W)) u_chk (.*);

// File: tb/tb_ovp_validator.sv
`timescale 1ns/1ps
module tb_ovp_validator;

    localparam int OVH_W = 11;
    localparam int EOC_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_wdata = '0;
    logic [7:0]       cfg_o;
    logic             sf_valid = 1'b0;
    logic [OVH_W-1:0] sf_ovh = '0;
    logic             sf_crc_err = 1'b0;
    logic             sf_febe = 1'b1;
    logic             hsf_valid = 1'b0;
    logic [EOC_W-1:0] hsf_msg = '0;
    logic [OVH_W-1:0] ovh_data;
    logic             ovh_irq;
    logic [EOC_W-1:0] eoc_data;
    logic             eoc_irq;
    logic             stat_irq, stat_ne_ok, stat_fe_ok, ne_cnt_inc, fe_cnt_inc;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ovp_validator #(.OVH_W(OVH_W), .EOC_W(EOC_W)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sf(input logic [OVH_W-1:0] d, input logic crc, input logic febe);
        @(negedge clk);
        sf_valid = 1'b1; sf_ovh = d; sf_crc_err = crc; sf_febe = febe;
        @(negedge clk);
        sf_valid = 1'b0; sf_crc_err = 1'b0; sf_febe = 1'b1;
    endtask

    task automatic hsf(input logic [EOC_W-1:0] m);
        @(negedge clk);
        hsf_valid = 1'b1; hsf_msg = m;
        @(negedge clk);
        hsf_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset cfg", 32'(cfg_o), 32'h00);
        chk("R1 reset ovh_data", 32'(ovh_data), 32'h0);
        chk("R10 reset irq", 32'({ovh_irq, eoc_irq, stat_irq}), 32'h0);
        wr_cfg(8'hFF);
        chk("R1 bit0 fixed", 32'(cfg_o), 32'hFE);
    endtask

    task automatic t_always();
        wr_cfg(8'h00);
        sf(11'h005, 1'b1, 1'b1);
        chk("R2 irq", 32'(ovh_irq), 1);
        chk("R2 data", 32'(ovh_data), 32'h005);
        chk("R7 disabled crc no irq", 32'(stat_irq), 0);
        chk("R9 ne count while disabled", 32'(ne_cnt_inc), 1);
        sf(11'h005, 1'b0, 1'b1);
        chk("R2 irq repeat", 32'(ovh_irq), 1);
        @(negedge clk);
        chk("R10 no strobe no irq", 32'(ovh_irq), 0);
    endtask

    task automatic t_change();
        wr_cfg(8'h08);
        sf(11'h005, 1'b0, 1'b1);
        chk("R3 same no irq", 32'(ovh_irq), 0);
        sf(11'h00A, 1'b0, 1'b1);
        chk("R3 change irq", 32'(ovh_irq), 1);
        chk("R3 change data", 32'(ovh_data), 32'h00A);
        sf(11'h00A, 1'b0, 1'b1);
        chk("R3 repeat no irq", 32'(ovh_irq), 0);
    endtask

    task automatic t_two();
        wr_cfg(8'h10);
        sf(11'h00B, 1'b0, 1'b1);
        chk("R4 two first no irq", 32'(ovh_irq), 0);
        sf(11'h00C, 1'b0, 1'b1);
        chk("R4 two restart no irq", 32'(ovh_irq), 0);
        chk("R5 data held", 32'(ovh_data), 32'h00A);
        sf(11'h00C, 1'b0, 1'b1);
        chk("R4 two second irq", 32'(ovh_irq), 1);
        chk("R4 two data", 32'(ovh_data), 32'h00C);
        sf(11'h00C, 1'b0, 1'b1);
        chk("R4 two validated no irq", 32'(ovh_irq), 0);
    endtask

    task automatic t_three();
        wr_cfg(8'h18);
        sf(11'h00D, 1'b0, 1'b1);
        sf(11'h00D, 1'b0, 1'b1);
        chk("R4 three two no irq", 32'(ovh_irq), 0);
        sf(11'h00C, 1'b0, 1'b1);
        sf(11'h00D, 1'b0, 1'b1);
        sf(11'h00D, 1'b0, 1'b1);
        chk("R4 three cleared by validated", 32'(ovh_irq), 0);
        sf(11'h00D, 1'b0, 1'b1);
        chk("R4 three third irq", 32'(ovh_irq), 1);
        chk("R4 three data", 32'(ovh_data), 32'h00D);
    endtask

    task automatic t_eoc();
        wr_cfg(8'h04);
        hsf(13'h0234);
        chk("R6 eoc first no irq", 32'(eoc_irq), 0);
        sf(11'h00D, 1'b0, 1'b1);
        chk("R6 ovh strobe irq", 32'(ovh_irq), 1);
        chk("R6 eoc untouched by sf", 32'({eoc_irq, eoc_data}), 32'h0);
        hsf(13'h0234);
        chk("R6 eoc second irq", 32'(eoc_irq), 1);
        chk("R6 eoc data", 32'(eoc_data), 32'h0234);
        wr_cfg(8'h00);
        hsf(13'h0234);
        chk("R6 eoc always irq", 32'(eoc_irq), 1);
    endtask

    task automatic t_status();
        wr_cfg(8'hA0);
        sf(11'h000, 1'b1, 1'b1);
        chk("R7 crc irq", 32'({stat_irq, stat_ne_ok, stat_fe_ok}), 32'b101);
        chk("R9 ne inc", 32'({ne_cnt_inc, fe_cnt_inc}), 32'b10);
        sf(11'h000, 1'b0, 1'b0);
        chk("R8 febe irq", 32'({stat_irq, stat_ne_ok, stat_fe_ok}), 32'b110);
        chk("R9 fe inc", 32'({ne_cnt_inc, fe_cnt_inc}), 32'b01);
        sf(11'h000, 1'b0, 1'b1);
        chk("R8 clean frame no irq", 32'(stat_irq), 0);
        wr_cfg(8'h00);
        sf(11'h000, 1'b0, 1'b0);
        chk("R8 disabled no irq", 32'(stat_irq), 0);
        chk("R9 fe inc while disabled", 32'(fe_cnt_inc), 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_always();
        t_change();
        t_two();
        t_three();
        t_eoc();
        t_status();
        summary();
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule